// File: doc/BRIEF.md
# Two-Player Game Clock Controller

This block runs a turn timer for a two-player game. It holds one countdown time bank for each player, in minutes and seconds. Only the bank of the player whose turn it is counts down. Each player has a move button that hands the turn to the opponent. A single settings button does three jobs: it picks the starting time, it starts the game, and it pauses and resumes play. The block drives two four-digit seven-segment displays through one shared, scanned segment bus. It also drives one turn LED per player, a two-bit flag output that names the player whose time ran out, and a square wave for a small speaker.

The block derives all of its time bases from a single system clock, which is 25 MHz by default. These are the one-second tick, the button filter window, the digit scan step and the tone half period. Each one is a parameter, so a small configuration can be exercised quickly.

Top module: `duel_clock`

## Requirements
- R1: After reset the clock is in setup. Both banks show 01:00, both LEDs are off, timeUp is 00 and speaker is low.
- R2: In setup, each settings press advances the preset through 01:00, 03:00, 05:00, 10:00 and back to 01:00, and loads the new preset into both banks.
- R3: In setup, a press of either move button arms the game. In the armed state, a settings press starts player A's bank and lights ledA only.
- R4: The running bank drops by one second every TICK_CYCLES running cycles. Banks are BCD MM:SS. A seconds value of 00 borrows to 59 from the minutes, and 10:00 steps to 09:59.
- R5: Only the bank of the player to move changes. While a bank runs, exactly one LED is lit, the one for its owner.
- R6: A press by the player to move passes the turn. If that press coincides with a tick, the tick is charged to the leaving player. The opponent's first decrement falls on the next tick boundary.
- R7: A move press by the player who is not to move has no effect on the turn or on either bank.
- R8: A settings press while running pauses the clock. Both banks are frozen, move presses are ignored, and the waiting player's LED stays lit. The next settings press resumes the same player.
- R9: A bank reaching 00:00 enters the flag state in the same cycle. That bank freezes and both LEDs go off. timeUp shows the player (bit 0 for A, bit 1 for B). Expiry wins over a move press in the same cycle.
- R10: On expiry, speaker toggles every TONE_HALF_CYCLES cycles for TICK_CYCLES cycles and then stays low.
- R11: In the flag state, move presses are ignored. A settings press returns to setup, clears timeUp and reloads the current preset into both banks.
- R12: digitN is active low with exactly one bit low. It steps one index every SCAN_CYCLES in the order 0 to 7 and wraps. Index 0 to 3 is A's seconds units, seconds tens, minutes units and minutes tens; index 4 to 7 is the same for B. segN is active low, with bit 0 as segment a through bit 6 as segment g, and always matches the digit that digitN selects.
- R13: Each button passes through two synchroniser flops and a filter that accepts a new level only after DEBOUNCE_CYCLES stable samples. A press acts once, on the filtered rising edge. A shorter pulse or a long hold gives no extra action.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| btnMoveA | input | 1 | Player A move button, raw level |
| btnMoveB | input | 1 | Player B move button, raw level |
| btnSet | input | 1 | Settings / start / pause button, raw level |
| segN | output | 7 | Segment drive a..g, active low |
| digitN | output | 8 | Digit select, active low, one at a time |
| ledA | output | 1 | Player A turn indicator |
| ledB | output | 1 | Player B turn indicator |
| timeUp | output | 2 | Expired player: bit 0 for A, bit 1 for B |
| speaker | output | 1 | Tone drive |

## Verification
The risky coincidence is a move press arriving in the same cycle as a one-second tick. It is checked in two variants: a plain handover, where the leaving player must be charged the second, and the final second of a bank, where expiry must win over the handover. The bench measures the button-to-action latency when it starts each game. It then releases a move press timed so that the action lands exactly on a tick edge. The result is judged from the decoded display digits, the turn LEDs and timeUp. A timing slip would show up as a turn passed without the charge, or as a missed flag.

// File: rtl/duel_clock_pkg.sv
package duel_clock_pkg;

  typedef enum logic [2:0] {
    ST_SETUP, ST_READY, ST_RUN_A, ST_RUN_B, ST_PAUSED, ST_FLAG
  } phase_t;

  typedef struct packed {
    logic [3:0] minT;
    logic [3:0] minO;
    logic [3:0] secT;
    logic [3:0] secO;
  } bcd_time_t;

  typedef struct packed {
    logic       loadPreset;
    logic [1:0] presetSel;
    logic       decA;
    logic       decB;
    logic       tickRun;
    logic       tickClr;
    logic       toneStart;
  } dp_ctrl_t;

  function automatic bcd_time_t presetTime(input logic [1:0] sel);
    case (sel)
      2'd0:    return bcd_time_t'(16'h0100);
      2'd1:    return bcd_time_t'(16'h0300);
      2'd2:    return bcd_time_t'(16'h0500);
      default: return bcd_time_t'(16'h1000);
    endcase
  endfunction

  function automatic bcd_time_t decTime(input bcd_time_t t);
    bcd_time_t r;
    r = t;
    if (t != '0) begin
      if (t.secO != 4'd0) r.secO = t.secO - 4'd1;
      else begin
        r.secO = 4'd9;
        if (t.secT != 4'd0) r.secT = t.secT - 4'd1;
        else begin
          r.secT = 4'd5;
          if (t.minO != 4'd0) r.minO = t.minO - 4'd1;
          else begin
            r.minO = 4'd9;
            r.minT = t.minT - 4'd1;
          end
        end
      end
    end
    return r;
  endfunction

  // active-high segment pattern, bit 0 = a ... bit 6 = g
  function automatic logic [6:0] seg7(input logic [3:0] d);
    case (d)
      4'd0: return 7'h3F;
      4'd1: return 7'h06;
      4'd2: return 7'h5B;
      4'd3: return 7'h4F;
      4'd4: return 7'h66;
      4'd5: return 7'h6D;
      4'd6: return 7'h7D;
      4'd7: return 7'h07;
      4'd8: return 7'h7F;
      4'd9: return 7'h6F;
      default: return 7'h00;
    endcase
  endfunction

endpackage

// File: rtl/duel_btn_filter.sv
module duel_btn_filter #(
  parameter int DEBOUNCE_CYCLES = 250000
) (
  input  logic clk,
  input  logic rst,
  input  logic rawIn,
  output logic pressed
);
  localparam int DW = $clog2(DEBOUNCE_CYCLES + 1);
  localparam logic [DW-1:0] DEB_LAST = DW'(DEBOUNCE_CYCLES - 1);

  logic [1:0]    syncQ;
  logic          level;
  logic          levelDly;
  logic [DW-1:0] stableCnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      syncQ     <= '0;
      level     <= 1'b0;
      levelDly  <= 1'b0;
      stableCnt <= '0;
    end else begin
      syncQ    <= {syncQ[0], rawIn};
      levelDly <= level;
      if (syncQ[1] != level) begin
        if (stableCnt == DEB_LAST) begin
          level     <= syncQ[1];
          stableCnt <= '0;
        end else begin
          stableCnt <= stableCnt + 1'b1;
        end
      end else begin
        stableCnt <= '0;
      end
    end
  end

  assign pressed = level & ~levelDly;

  // R13: one action per press
  p_single_pulse_r13: assert property (@(posedge clk) disable iff (rst)
    pressed |=> !pressed);

endmodule

// File: rtl/duel_ctrl.sv
module duel_ctrl
  import duel_clock_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       pressA,
  input  logic       pressB,
  input  logic       pressSet,
  input  logic       tick,
  input  logic       lastA,
  input  logic       lastB,
  output dp_ctrl_t   ctl,
  output logic       ledA,
  output logic       ledB,
  output logic [1:0] timeUp
);
  phase_t     phase, phaseNx;
  logic       resumeB, resumeNx;
  logic [1:0] presetIdx, presetNx;
  logic [1:0] flagWho, flagNx;
  logic       expireA, expireB;

  assign expireA = tick && lastA && (phase == ST_RUN_A);
  assign expireB = tick && lastB && (phase == ST_RUN_B);

  always_comb begin
    phaseNx  = phase;
    resumeNx = resumeB;
    presetNx = presetIdx;
    flagNx   = flagWho;
    ctl           = '0;
    ctl.presetSel = presetIdx;
    ctl.tickRun   = (phase == ST_RUN_A) || (phase == ST_RUN_B);
    ctl.tickClr   = (phase == ST_SETUP) || (phase == ST_READY) || (phase == ST_FLAG);
    ctl.decA      = tick && (phase == ST_RUN_A);
    ctl.decB      = tick && (phase == ST_RUN_B);
    unique case (phase)
      ST_SETUP: begin
        if (pressSet) begin
          presetNx       = presetIdx + 2'd1;
          ctl.presetSel  = presetIdx + 2'd1;
          ctl.loadPreset = 1'b1;
        end else if (pressA || pressB) begin
          phaseNx = ST_READY;
        end
      end
      ST_READY: if (pressSet) phaseNx = ST_RUN_A;
      ST_RUN_A: begin
        if (expireA) begin
          phaseNx = ST_FLAG; flagNx = 2'b01; ctl.toneStart = 1'b1;
        end else if (pressSet) begin
          phaseNx = ST_PAUSED; resumeNx = 1'b0;
        end else if (pressA) phaseNx = ST_RUN_B;
      end
      ST_RUN_B: begin
        if (expireB) begin
          phaseNx = ST_FLAG; flagNx = 2'b10; ctl.toneStart = 1'b1;
        end else if (pressSet) begin
          phaseNx = ST_PAUSED; resumeNx = 1'b1;
        end else if (pressB) phaseNx = ST_RUN_A;
      end
      ST_PAUSED: if (pressSet) phaseNx = resumeB ? ST_RUN_B : ST_RUN_A;
      ST_FLAG: begin
        if (pressSet) begin
          phaseNx = ST_SETUP; flagNx = 2'b00; ctl.loadPreset = 1'b1;
        end
      end
      default: phaseNx = ST_SETUP;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= ST_SETUP;
      resumeB   <= 1'b0;
      presetIdx <= 2'd0;
      flagWho   <= 2'b00;
    end else begin
      phase     <= phaseNx;
      resumeB   <= resumeNx;
      presetIdx <= presetNx;
      flagWho   <= flagNx;
    end
  end

  assign ledA   = (phase == ST_RUN_A) || (phase == ST_PAUSED && !resumeB);
  assign ledB   = (phase == ST_RUN_B) || (phase == ST_PAUSED && resumeB);
  assign timeUp = flagWho;

  // R5: one turn LED while a bank runs
  p_one_led_r5: assert property (@(posedge clk) disable iff (rst)
    (phase == ST_RUN_A || phase == ST_RUN_B) |-> (ledA != ledB));
  // R6: active press hands the turn over
  p_turn_pass_r6: assert property (@(posedge clk) disable iff (rst)
    (phase == ST_RUN_A && pressA && !pressSet && !(tick && lastA)) |=> phase == ST_RUN_B);
  // R7: press of the waiting player ignored
  p_inactive_r7: assert property (@(posedge clk) disable iff (rst)
    (phase == ST_RUN_B && pressA && !pressB && !pressSet && !(tick && lastB)) |=> phase == ST_RUN_B);
  // R9: expiry wins over any press
  p_expiry_r9: assert property (@(posedge clk) disable iff (rst)
    (phase == ST_RUN_A && tick && lastA) |=> (phase == ST_FLAG && timeUp == 2'b01 && !ledA && !ledB));
  // R11: flag held until settings press
  p_flag_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (phase == ST_FLAG && !pressSet) |=> (phase == ST_FLAG && $stable(timeUp)));

endmodule

// File: rtl/duel_dp.sv
module duel_dp
  import duel_clock_pkg::*;
#(
  parameter int TICK_CYCLES      = 25000000,
  parameter int SCAN_CYCLES      = 3125,
  parameter int TONE_HALF_CYCLES = 6250
) (
  input  logic       clk,
  input  logic       rst,
  input  dp_ctrl_t   ctl,
  output logic       tick,
  output logic       lastA,
  output logic       lastB,
  output logic [6:0] segN,
  output logic [7:0] digitN,
  output logic       speaker
);
  localparam int TW = $clog2(TICK_CYCLES + 1);
  localparam logic [TW-1:0] TICK_LAST = TW'(TICK_CYCLES - 1);
  localparam logic [TW-1:0] TICK_FULL = TW'(TICK_CYCLES);
  localparam int SW = $clog2(SCAN_CYCLES + 1);
  localparam logic [SW-1:0] SCAN_LAST = SW'(SCAN_CYCLES - 1);
  localparam int HW = $clog2(TONE_HALF_CYCLES + 1);
  localparam logic [HW-1:0] HALF_LAST = HW'(TONE_HALF_CYCLES - 1);

  bcd_time_t bank [2];
  logic [1:0] decVec;
  assign decVec = {ctl.decB, ctl.decA};

  for (genvar p = 0; p < 2; p++) begin : g_bank
    always_ff @(posedge clk) begin
      if (rst)                 bank[p] <= presetTime(2'd0);
      else if (ctl.loadPreset) bank[p] <= presetTime(ctl.presetSel);
      else if (decVec[p])      bank[p] <= decTime(bank[p]);
    end

    // R5: a bank moves only on its own strobe or a preset load
    p_bank_hold_r5: assert property (@(posedge clk) disable iff (rst)
      (!ctl.loadPreset && !decVec[p]) |=> $stable(bank[p]));
    // R4: every digit stays legal BCD
    p_bcd_r4: assert property (@(posedge clk) disable iff (rst)
      bank[p].secO <= 4'd9 && bank[p].secT <= 4'd5 && bank[p].minO <= 4'd9 && bank[p].minT <= 4'd9);
  end

  assign lastA = (bank[0] == bcd_time_t'(16'h0001));
  assign lastB = (bank[1] == bcd_time_t'(16'h0001));

  // one-second time base, held in pause, cleared outside play
  logic [TW-1:0] tickCnt;
  always_ff @(posedge clk) begin
    if (rst || ctl.tickClr) tickCnt <= '0;
    else if (ctl.tickRun)   tickCnt <= (tickCnt == TICK_LAST) ? '0 : tickCnt + 1'b1;
  end
  assign tick = ctl.tickRun && (tickCnt == TICK_LAST);

  // display scan: digit select and segments registered as a pair
  logic [SW-1:0] scanDiv;
  logic [2:0]    scanIdx;
  bcd_time_t     scanBank;
  logic [3:0]    scanDigit;

  always_comb begin
    scanBank = bank[scanIdx[2]];
    case (scanIdx[1:0])
      2'd0:    scanDigit = scanBank.secO;
      2'd1:    scanDigit = scanBank.secT;
      2'd2:    scanDigit = scanBank.minO;
      default: scanDigit = scanBank.minT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      scanDiv <= '0;
      scanIdx <= 3'd0;
      digitN  <= 8'hFE;
      segN    <= 7'h7F;
    end else begin
      if (scanDiv == SCAN_LAST) begin
        scanDiv <= '0;
        scanIdx <= scanIdx + 3'd1;
      end else begin
        scanDiv <= scanDiv + 1'b1;
      end
      digitN <= ~(8'd1 << scanIdx);
      segN   <= ~seg7(scanDigit);
    end
  end

  // R12: one digit driven at a time
  p_digit_onehot_r12: assert property (@(posedge clk) disable iff (rst)
    $countones(~digitN) == 1);

  // expiry tone
  logic [TW-1:0] toneLeft;
  logic [HW-1:0] halfCnt;
  always_ff @(posedge clk) begin
    if (rst) begin
      toneLeft <= '0;
      halfCnt  <= '0;
      speaker  <= 1'b0;
    end else if (ctl.toneStart) begin
      toneLeft <= TICK_FULL;
      halfCnt  <= '0;
      speaker  <= 1'b0;
    end else if (toneLeft != '0) begin
      toneLeft <= toneLeft - 1'b1;
      if (halfCnt == HALF_LAST) begin
        halfCnt <= '0;
        speaker <= ~speaker;
      end else begin
        halfCnt <= halfCnt + 1'b1;
      end
    end else begin
      halfCnt <= '0;
      speaker <= 1'b0;
    end
  end

  // R10: silent once the tone window has run out
  p_tone_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    (toneLeft == '0 && !ctl.toneStart) |=> !speaker);

endmodule

// File: rtl/duel_clock.sv
module duel_clock #(
  parameter int CLK_HZ           = 25000000,
  parameter int TICK_CYCLES      = CLK_HZ,
  parameter int DEBOUNCE_CYCLES  = CLK_HZ / 100,
  parameter int SCAN_CYCLES      = CLK_HZ / 8000,
  parameter int TONE_HALF_CYCLES = CLK_HZ / 4000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       btnMoveA,
  input  logic       btnMoveB,
  input  logic       btnSet,
  output logic [6:0] segN,
  output logic [7:0] digitN,
  output logic       ledA,
  output logic       ledB,
  output logic [1:0] timeUp,
  output logic       speaker
);
  import duel_clock_pkg::*;

  logic [2:0] rawBtn;
  logic [2:0] pressVec;
  assign rawBtn = {btnSet, btnMoveB, btnMoveA};

  for (genvar i = 0; i < 3; i++) begin : g_btn
    duel_btn_filter #(.DEBOUNCE_CYCLES(DEBOUNCE_CYCLES)) u_filt (
      .clk(clk), .rst(rst), .rawIn(rawBtn[i]), .pressed(pressVec[i]));
  end

  dp_ctrl_t ctl;
  logic tick, lastA, lastB;

  duel_ctrl u_ctrl (
    .clk(clk), .rst(rst),
    .pressA(pressVec[0]), .pressB(pressVec[1]), .pressSet(pressVec[2]),
    .tick(tick), .lastA(lastA), .lastB(lastB),
    .ctl(ctl), .ledA(ledA), .ledB(ledB), .timeUp(timeUp));

  duel_dp #(
    .TICK_CYCLES(TICK_CYCLES), .SCAN_CYCLES(SCAN_CYCLES),
    .TONE_HALF_CYCLES(TONE_HALF_CYCLES)
  ) u_dp (
    .clk(clk), .rst(rst), .ctl(ctl),
    .tick(tick), .lastA(lastA), .lastB(lastB),
    .segN(segN), .digitN(digitN), .speaker(speaker));

endmodule

// File: tb/duel_clock_test.sv
`timescale 1ns/1ps
module duel_clock_test;
  localparam int TK = 40;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic btnMoveA = 1'b0, btnMoveB = 1'b0, btnSet = 1'b0;
  logic [6:0] segN;
  logic [7:0] digitN;
  logic ledA, ledB, speaker;
  logic [1:0] timeUp;

  duel_clock #(.CLK_HZ(4000), .TICK_CYCLES(TK), .DEBOUNCE_CYCLES(4),
               .SCAN_CYCLES(2), .TONE_HALF_CYCLES(3)) uut (
    .clk(clk), .rst(rst), .btnMoveA(btnMoveA), .btnMoveB(btnMoveB), .btnSet(btnSet),
    .segN(segN), .digitN(digitN), .ledA(ledA), .ledB(ledB),
    .timeUp(timeUp), .speaker(speaker));

  always #2.5 clk = ~clk;

  longint cyc = 0;
  int checks = 0, fails = 0;
  longint lat = 7;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [3:0] segDecode(input logic [6:0] s);
    case (s)
      7'h3F: return 4'd0; 7'h06: return 4'd1; 7'h5B: return 4'd2;
      7'h4F: return 4'd3; 7'h66: return 4'd4; 7'h6D: return 4'd5;
      7'h7D: return 4'd6; 7'h07: return 4'd7; 7'h7F: return 4'd8;
      7'h6F: return 4'd9; default: return 4'hF;
    endcase
  endfunction

  // collect all eight digits from the scan (R12)
  task automatic readClock(output logic [15:0] a, output logic [15:0] b);
    logic [7:0] seen = '0;
    logic [31:0] both = '0;
    bit scanOk = 1;
    int prevIdx = -1;
    for (int i = 0; i < 60 && seen != 8'hFF; i++) begin
      int idx = -1;
      @(negedge clk);
      if ($countones(~digitN) != 1) scanOk = 0;
      for (int k = 0; k < 8; k++) if (!digitN[k]) idx = k;
      if (idx >= 0) begin
        if (prevIdx >= 0 && idx != prevIdx && idx != ((prevIdx + 1) % 8)) scanOk = 0;
        if (segDecode(~segN) == 4'hF) scanOk = 0;
        both[idx*4 +: 4] = segDecode(~segN);
        seen[idx] = 1'b1;
        prevIdx = idx;
      end
    end
    check(scanOk && seen == 8'hFF, "R12", "scan order/encoding", {24'd0, seen}, 32'hFF);
    a = both[15:0];
    b = both[31:16];
  endtask

  task automatic expectClock(input string req, input logic [15:0] ea, input logic [15:0] eb);
    logic [15:0] a, b;
    readClock(a, b);
    check(a == ea, req, "bank A", {16'd0, a}, {16'd0, ea});
    check(b == eb, req, "bank B", {16'd0, b}, {16'd0, eb});
  endtask

  task automatic setBtn(input int which, input logic v);
    case (which)
      0: btnMoveA = v;
      1: btnMoveB = v;
      default: btnSet = v;
    endcase
  endtask

  task automatic waitUntil(input longint t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic pressAt(input int which, input longint t);
    waitUntil(t);
    setBtn(which, 1'b1);
    repeat (10) @(negedge clk);
    setBtn(which, 1'b0);
    repeat (10) @(negedge clk);
  endtask

  task automatic pressBtn(input int which);
    @(negedge clk);
    pressAt(which, cyc);
    repeat (10) @(negedge clk);
  endtask

  // start from the armed state, measuring press-to-action latency
  task automatic startRunA(output longint e);
    longint c0;
    bit got = 0;
    e = 0;
    @(negedge clk);
    btnSet = 1'b1;
    c0 = cyc;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (i == 10) btnSet = 1'b0;
      if (ledA && !got) begin got = 1; e = cyc; end
      if (got && i >= 10) break;
    end
    btnSet = 1'b0;
    lat = e - c0;
    check(got && ledA && !ledB, "R3", "start lights A only", {30'd0, ledA, ledB}, 32'h2);
  endtask

  initial begin
    longint e;
    logic [15:0] a1, b1, a2, b2;
    int toggles, highs;
    logic prevSpk;

    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (20) @(negedge clk);
    // R1 reset state
    check(!ledA && !ledB, "R1", "LEDs off", {30'd0, ledA, ledB}, 0);
    check(timeUp == 2'b00 && !speaker, "R1", "flag/speaker idle", {29'd0, timeUp, speaker}, 0);
    expectClock("R1", 16'h0100, 16'h0100);

    // R2 preset cycle
    pressBtn(2); expectClock("R2", 16'h0300, 16'h0300);
    pressBtn(2); expectClock("R2", 16'h0500, 16'h0500);
    pressBtn(2); expectClock("R2", 16'h1000, 16'h1000);
    pressBtn(2); expectClock("R2", 16'h0100, 16'h0100);

    // R3 arm with B's button, start
    pressBtn(1);
    check(!ledA && !ledB, "R3", "armed LEDs off", {30'd0, ledA, ledB}, 0);
    startRunA(e);
    expectClock("R3", 16'h0100, 16'h0100);
    waitUntil(e + 43);
    expectClock("R4", 16'h0059, 16'h0100);   // borrow, only A runs (R5)

    // R6 handover landing on the tick edge e+80
    pressAt(0, e + 80 - lat);
    check(!ledA && ledB, "R6", "turn passed to B", {30'd0, ledA, ledB}, 32'h1);
    expectClock("R6", 16'h0058, 16'h0100);
    waitUntil(e + 123);
    expectClock("R6", 16'h0058, 16'h0059);

    // R7 press by waiting player
    pressAt(0, e + 145);
    check(!ledA && ledB, "R7", "turn kept by B", {30'd0, ledA, ledB}, 32'h1);
    expectClock("R7", 16'h0058, 16'h0058);

    // R8 pause
    pressAt(2, e + 186);
    check(!ledA && ledB, "R8", "paused LED", {30'd0, ledA, ledB}, 32'h1);
    readClock(a1, b1);
    repeat (150) @(negedge clk);
    pressBtn(1);
    pressBtn(0);
    readClock(a2, b2);
    check(a1 == a2 && b1 == b2 && b2 == 16'h0058, "R8", "frozen in pause", {a2, b2}, {a1, b1});
    check(!ledA && ledB, "R8", "move ignored in pause", {30'd0, ledA, ledB}, 32'h1);
    pressBtn(2);
    check(!ledA && ledB, "R8", "resumed B", {30'd0, ledA, ledB}, 32'h1);

    // R9 B runs out
    for (int i = 0; i < 4000 && timeUp == 2'b00; i++) @(negedge clk);
    check(timeUp == 2'b10, "R9", "flag names B", {30'd0, timeUp}, 32'h2);
    check(!ledA && !ledB, "R9", "LEDs off at flag", {30'd0, ledA, ledB}, 0);
    toggles = 0;
    prevSpk = speaker;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (speaker != prevSpk) toggles++;
      prevSpk = speaker;
    end
    check(toggles >= 4, "R10", "tone toggles", toggles, 4);
    repeat (40) @(negedge clk);
    highs = 0;
    for (int i = 0; i < 50; i++) begin @(negedge clk); if (speaker) highs++; end
    check(highs == 0, "R10", "silent after window", highs, 0);
    expectClock("R9", 16'h0058, 16'h0000);
    pressBtn(0);
    pressBtn(1);
    expectClock("R11", 16'h0058, 16'h0000);
    check(timeUp == 2'b10, "R11", "flag kept", {30'd0, timeUp}, 32'h2);

    // R11 back to setup, game 2: expiry vs coincident move
    pressBtn(2);
    check(timeUp == 2'b00, "R11", "flag cleared", {30'd0, timeUp}, 0);
    expectClock("R11", 16'h0100, 16'h0100);
    pressBtn(0);
    startRunA(e);
    pressAt(0, e + 60 * TK - lat);
    waitUntil(e + 60 * TK + 10);
    check(timeUp == 2'b01, "R9", "expiry beats move press", {30'd0, timeUp}, 32'h1);
    check(!ledA && !ledB, "R9", "LEDs off", {30'd0, ledA, ledB}, 0);
    expectClock("R9", 16'h0000, 16'h0100);

    // R13 filter: glitch and long hold
    pressBtn(2);
    @(negedge clk); btnSet = 1'b1;
    repeat (2) @(negedge clk); btnSet = 1'b0;
    repeat (20) @(negedge clk);
    expectClock("R13", 16'h0100, 16'h0100);
    btnSet = 1'b1;
    repeat (40) @(negedge clk); btnSet = 1'b0;
    repeat (20) @(negedge clk);
    expectClock("R13", 16'h0300, 16'h0300);
    pressBtn(2);
    pressBtn(2);
    expectClock("R2", 16'h1000, 16'h1000);
    pressBtn(1);
    startRunA(e);
    waitUntil(e + 43);
    expectClock("R4", 16'h0959, 16'h1000);

    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    #(150000 * 5);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule